// File: doc/BRIEF.md
# Banked Button Controller for Audio Level Control

This block turns six active-low push-button inputs into control settings for an audio processor. Every input passes through a two-flop synchronizer and a debouncer that is timed from a sample-rate tick. Each clean press edge then applies exactly one action, and holding a button down never repeats that action.

The buttons work in one of two banks. The tone bank raises or lowers volume, bass and treble in 1 dB steps. The preset bank toggles mute and picks one of five equalizer presets. To change bank, hold a two-button chord for one second. The chord is different in each bank. While a chord is fully held, the two buttons that form it take no single-button action. After a switch, no new switch can start until every button has been released.

The outputs are signed dB codes for volume, bass and treble, a mute flag, a preset index and the current bank. Only the settings are produced here. Applying the gains to audio samples is done elsewhere.

Top module: `gpi_bank_ctrl`

## Requirements
- R1: After reset, the outputs are: volume −40 dB, bass 0 dB, treble 0 dB, mute 0, preset index 0 and bank 0 (tone bank).
- R2: A change of input level must hold for SAMPLE_RATE_HZ·20/1000 consecutive ticks before it counts. A shorter pulse has no effect on any output.
- R3: In the tone bank, each press of an input (bit i of `gpi_n` going low) applies one step: bit 5 raises volume 1 dB, bit 4 lowers volume, bit 3 raises bass, bit 2 lowers bass, bit 1 raises treble, bit 0 lowers treble. A held press applies exactly one step.
- R4: Bass and treble saturate at +15 dB and −15 dB.
- R5: Volume saturates at +18 dB. A volume-down press when volume is already at the floor (−70 dB by default) leaves the level unchanged and sets mute.
- R6: In the tone bank, a volume-up press while mute is set clears mute and leaves the level unchanged.
- R7: Holding bits 1 and 5 pressed together for SAMPLE_RATE_HZ ticks in the tone bank switches to the preset bank (bank output 1). While both bits are held, a press edge on either of them does nothing.
- R8: In the preset bank, a bit 5 press toggles mute. A press on bit 4, 3, 2, 1 or 0 sets the preset index to 0, 1, 2, 3 or 4 respectively. Volume, bass and treble do not change.
- R9: Holding bits 0 and 4 together for SAMPLE_RATE_HZ ticks in the preset bank returns to the tone bank. Once a switch has happened, no further switch can occur until all six inputs are released.
- R10: If a chord is released before its hold time completes, the bank does not change. The next attempt starts timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse at the audio sample rate |
| gpi_n | input | 6 | Button inputs, low = pressed |
| vol_db | output | 8 | Volume level, signed dB |
| bass_db | output | 8 | Bass level, signed dB |
| treble_db | output | 8 | Treble level, signed dB |
| mute | output | 1 | Mute state |
| eq_sel | output | 3 | Equalizer preset index, 0 to 4 |
| bank | output | 1 | Active bank: 0 tone, 1 preset |

## Verification
The assertions rely on three assumptions. First, the decoded actions of one cycle never raise and lower the same level at once. Second, a bank change and a level change do not come from the same press. Third, `tick` is a pulse and not a level. The stimulus meets these assumptions as follows. It presses one button at a time and holds each level far longer than the debounce window before changing it. It forms chords by pressing the two buttons one after the other. It drives `tick` as a strict alternation.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    localparam int NUM_GPI = 6;
    localparam int LVL_W   = 8;
    localparam int NUM_EQ  = 5;
    localparam int EQ_W    = $clog2(NUM_EQ);

    // bit positions of the tone-bank functions
    localparam int BTN_VOL_UP  = 5;
    localparam int BTN_VOL_DN  = 4;
    localparam int BTN_BASS_UP = 3;
    localparam int BTN_BASS_DN = 2;
    localparam int BTN_TREB_UP = 1;
    localparam int BTN_TREB_DN = 0;
    localparam int BTN_MUTE    = 5;

    // chord that leaves each bank
    localparam logic [NUM_GPI-1:0] CHORD_TONE   = 6'b100010;
    localparam logic [NUM_GPI-1:0] CHORD_PRESET = 6'b010001;

    typedef logic signed [LVL_W-1:0] lvl_t;

    typedef enum logic {
        BANK_TONE   = 1'b0,
        BANK_PRESET = 1'b1
    } bank_e;

    typedef struct packed {
        logic            vol_up;
        logic            vol_dn;
        logic            bass_up;
        logic            bass_dn;
        logic            treb_up;
        logic            treb_dn;
        logic            mute_tgl;
        logic            eq_vld;
        logic [EQ_W-1:0] eq_idx;
    } act_s;

    // one saturating step; simultaneous up and down cancel
    function automatic lvl_t step_lvl(lvl_t cur, logic up, logic dn, int lo, int hi);
        int v;
        v = int'(cur);
        if (up && !dn && v < hi)
            v = v + 1;
        else if (dn && !up && v > lo)
            v = v - 1;
        return lvl_t'(v);
    endfunction

endpackage

// File: rtl/gpi_debounce.sv
module gpi_debounce
    import gpi_pkg::*;
#(
    parameter int N         = NUM_GPI,
    parameter int DEB_TICKS = 960
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] gpi_n,
    output logic [N-1:0] pressed,
    output logic [N-1:0] press_evt
);

    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [N-1:0] pressed_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic          sync0, sync1;
        logic [CW-1:0] cnt;
        logic          stab;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync0 <= 1'b1;
                sync1 <= 1'b1;
                cnt   <= '0;
                stab  <= 1'b0;
            end else begin
                sync0 <= gpi_n[i];
                sync1 <= sync0;
                if (~sync1 == stab) begin
                    cnt <= '0;
                end else if (tick) begin
                    if (cnt == CW'(DEB_TICKS - 1)) begin
                        stab <= ~sync1;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end

        assign pressed[i] = stab;
    end

    always_ff @(posedge clk) begin
        if (rst) pressed_q <= '0;
        else     pressed_q <= pressed;
    end

    assign press_evt = pressed & ~pressed_q;

endmodule

// File: rtl/gpi_chord_timer.sv
module gpi_chord_timer
    import gpi_pkg::*;
#(
    parameter int HOLD_TICKS = 48000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_GPI-1:0] pressed,
    output bank_e              bank,
    output logic [NUM_GPI-1:0] chord_mask,
    output logic               chord_full
);

    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] cnt;
    logic          blocked;

    assign chord_mask = (bank == BANK_TONE) ? CHORD_TONE : CHORD_PRESET;
    assign chord_full = (pressed & chord_mask) == chord_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank    <= BANK_TONE;
            cnt     <= '0;
            blocked <= 1'b0;
        end else begin
            if (pressed == '0)
                blocked <= 1'b0;
            if (!chord_full || blocked) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == HW'(HOLD_TICKS - 1)) begin
                    bank    <= (bank == BANK_TONE) ? BANK_PRESET : BANK_TONE;
                    cnt     <= '0;
                    blocked <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gpi_action_decode.sv
module gpi_action_decode
    import gpi_pkg::*;
(
    input  bank_e              bank,
    input  logic [NUM_GPI-1:0] press_evt,
    input  logic [NUM_GPI-1:0] chord_mask,
    input  logic               chord_full,
    output act_s               act
);

    logic [NUM_GPI-1:0] evt;

    assign evt = press_evt & ~(chord_full ? chord_mask : '0);

    always_comb begin
        act = '0;
        if (bank == BANK_TONE) begin
            act.vol_up  = evt[BTN_VOL_UP];
            act.vol_dn  = evt[BTN_VOL_DN];
            act.bass_up = evt[BTN_BASS_UP];
            act.bass_dn = evt[BTN_BASS_DN];
            act.treb_up = evt[BTN_TREB_UP];
            act.treb_dn = evt[BTN_TREB_DN];
        end else begin
            act.mute_tgl = evt[BTN_MUTE];
            // higher bit wins when several presets land together
            for (int i = 0; i < NUM_EQ; i++) begin
                if (evt[i]) begin
                    act.eq_vld = 1'b1;
                    act.eq_idx = EQ_W'(NUM_EQ - 1 - i);
                end
            end
        end
    end

endmodule

// File: rtl/gpi_level_regs.sv
module gpi_level_regs
    import gpi_pkg::*;
#(
    parameter int VOL_MIN_DB = -70,
    parameter int VOL_MAX_DB = 18,
    parameter int VOL_RST_DB = -40,
    parameter int TONE_LIM   = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  act_s            act,
    output lvl_t            vol_db,
    output lvl_t            bass_db,
    output lvl_t            treble_db,
    output logic            mute,
    output logic [EQ_W-1:0] eq_sel
);

    logic vol_at_floor;

    assign vol_at_floor = int'(vol_db) == VOL_MIN_DB;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_db    <= lvl_t'(VOL_RST_DB);
            bass_db   <= '0;
            treble_db <= '0;
            mute      <= 1'b0;
            eq_sel    <= '0;
        end else begin
            bass_db   <= step_lvl(bass_db, act.bass_up, act.bass_dn, -TONE_LIM, TONE_LIM);
            treble_db <= step_lvl(treble_db, act.treb_up, act.treb_dn, -TONE_LIM, TONE_LIM);

            if (act.vol_up && !act.vol_dn) begin
                if (mute) mute   <= 1'b0;
                else      vol_db <= step_lvl(vol_db, 1'b1, 1'b0, VOL_MIN_DB, VOL_MAX_DB);
            end else if (act.vol_dn && !act.vol_up) begin
                if (vol_at_floor) mute   <= 1'b1;
                else              vol_db <= step_lvl(vol_db, 1'b0, 1'b1, VOL_MIN_DB, VOL_MAX_DB);
            end else if (act.mute_tgl) begin
                mute <= ~mute;
            end

            if (act.eq_vld)
                eq_sel <= act.eq_idx;
        end
    end

endmodule

// File: rtl/gpi_bank_ctrl.sv
module gpi_bank_ctrl
    import gpi_pkg::*;
#(
    parameter int SAMPLE_RATE_HZ = 48000,
    parameter int DEBOUNCE_MS    = 20,
    parameter int HOLD_MS        = 1000,
    parameter int VOL_MIN_DB     = -70,
    parameter int VOL_MAX_DB     = 18,
    parameter int VOL_RST_DB     = -40,
    parameter int TONE_LIM       = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic [5:0]              gpi_n,
    output logic signed [7:0]       vol_db,
    output logic signed [7:0]       bass_db,
    output logic signed [7:0]       treble_db,
    output logic                    mute,
    output logic [2:0]              eq_sel,
    output logic                    bank
);

    localparam int DEB_TICKS  = SAMPLE_RATE_HZ * DEBOUNCE_MS / 1000;
    localparam int HOLD_TICKS = SAMPLE_RATE_HZ * HOLD_MS / 1000;

    logic [NUM_GPI-1:0] pressed;
    logic [NUM_GPI-1:0] press_evt;
    logic [NUM_GPI-1:0] chord_mask;
    logic               chord_full;
    bank_e              bank_q;
    act_s               act;

    gpi_debounce #(
        .N         (NUM_GPI),
        .DEB_TICKS (DEB_TICKS)
    ) u_deb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .gpi_n     (gpi_n),
        .pressed   (pressed),
        .press_evt (press_evt)
    );

    gpi_chord_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_chord (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pressed    (pressed),
        .bank       (bank_q),
        .chord_mask (chord_mask),
        .chord_full (chord_full)
    );

    gpi_action_decode u_dec (
        .bank       (bank_q),
        .press_evt  (press_evt),
        .chord_mask (chord_mask),
        .chord_full (chord_full),
        .act        (act)
    );

    gpi_level_regs #(
        .VOL_MIN_DB (VOL_MIN_DB),
        .VOL_MAX_DB (VOL_MAX_DB),
        .VOL_RST_DB (VOL_RST_DB),
        .TONE_LIM   (TONE_LIM)
    ) u_lvl (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .vol_db    (vol_db),
        .bass_db   (bass_db),
        .treble_db (treble_db),
        .mute      (mute),
        .eq_sel    (eq_sel)
    );

    assign bank = bank_q;

endmodule

// File: rtl/gpi_bank_ctrl_chk.sv
module gpi_bank_ctrl_chk #(
    parameter int VOL_MIN_DB = -70,
    parameter int VOL_MAX_DB = 18,
    parameter int VOL_RST_DB = -40,
    parameter int TONE_LIM   = 15
) (
    input logic              clk,
    input logic              rst,
    input logic signed [7:0] vol_db,
    input logic signed [7:0] bass_db,
    input logic signed [7:0] treble_db,
    input logic              mute,
    input logic [2:0]        eq_sel,
    input logic              bank
);

    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int'(vol_db) == VOL_RST_DB && bass_db == 0 && treble_db == 0
                        && !mute && eq_sel == 0 && !bank));

    // R4
    bass_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bass_db) <= TONE_LIM && int'(bass_db) >= -TONE_LIM);

    // R4
    treble_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(treble_db) <= TONE_LIM && int'(treble_db) >= -TONE_LIM);

    // R5
    vol_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(vol_db) <= VOL_MAX_DB && int'(vol_db) >= VOL_MIN_DB);

    // R3
    bass_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bass_db) |-> ((int'(bass_db) - int'($past(bass_db))) == 1
                               || (int'(bass_db) - int'($past(bass_db))) == -1));

    // R3
    vol_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vol_db) |-> ((int'(vol_db) - int'($past(vol_db))) == 1
                              || (int'(vol_db) - int'($past(vol_db))) == -1));

    // R8
    tone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bank) |-> ($stable(vol_db) && $stable(bass_db) && $stable(treble_db)));

    // R8
    eq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bank) |-> $stable(eq_sel));

    // R8
    eq_range_chk: assert property (@(posedge clk) disable iff (rst)
        eq_sel < 3'd5);

    // R5
    mute_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mute) |-> ($past(bank) || int'($past(vol_db)) == VOL_MIN_DB));

endmodule

bind gpi_bank_ctrl gpi_bank_ctrl_chk #(
    .VOL_MIN_DB (VOL_MIN_DB),
    .VOL_MAX_DB (VOL_MAX_DB),
    .VOL_RST_DB (VOL_RST_DB),
    .TONE_LIM   (TONE_LIM)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vol_db    (vol_db),
    .bass_db   (bass_db),
    .treble_db (treble_db),
    .mute      (mute),
    .eq_sel    (eq_sel),
    .bank      (bank)
);

// File: tb/sim_gpi_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpi_bank_ctrl;

    localparam int RATE      = 200;          // 4 debounce ticks, 200 hold ticks
    localparam int HOLD_CLKS = RATE * 2;     // tick every other clock
    localparam int SETTLE    = 30;
    localparam int VMIN = -70, VMAX = 18, TLIM = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic [5:0]        gpi_n = '1;
    logic signed [7:0] vol_db, bass_db, treble_db;
    logic              mute;
    logic [2:0]        eq_sel;
    logic              bank;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int e_vol = -40, e_bass = 0, e_treb = 0, e_mute = 0, e_eq = 0, e_bank = 0;

    always #10 clk = ~clk;

    gpi_bank_ctrl #(.SAMPLE_RATE_HZ(RATE)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .gpi_n(gpi_n),
        .vol_db(vol_db), .bass_db(bass_db), .treble_db(treble_db),
        .mute(mute), .eq_sel(eq_sel), .bank(bank)
    );

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(int'(vol_db), e_vol, req, "vol");
        chk(int'(bass_db), e_bass, req, "bass");
        chk(int'(treble_db), e_treb, req, "treble");
        chk(int'(mute), e_mute, req, "mute");
        chk(int'(eq_sel), e_eq, req, "eq_sel");
        chk(int'(bank), e_bank, req, "bank");
    endtask

    // expected effect of one press of bit i
    task automatic model(input int i);
        if (e_bank == 0) begin
            case (i)
                5: if (e_mute != 0) e_mute = 0; else if (e_vol < VMAX) e_vol++;
                4: if (e_vol == VMIN) e_mute = 1; else e_vol--;
                3: if (e_bass < TLIM) e_bass++;
                2: if (e_bass > -TLIM) e_bass--;
                1: if (e_treb < TLIM) e_treb++;
                default: if (e_treb > -TLIM) e_treb--;
            endcase
        end else begin
            if (i == 5) e_mute = 1 - e_mute;
            else        e_eq = 4 - i;
        end
    endtask

    task automatic press(input int i, input string req);
        gpi_n[i] = 1'b0;
        wait_clk(SETTLE);
        model(i);
        check_all(req);
        gpi_n[i] = 1'b1;
        wait_clk(SETTLE);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check_all("R1");

        // R2: glitch of 3 clocks is shorter than 4 ticks
        gpi_n[5] = 1'b0;
        wait_clk(3);
        gpi_n[5] = 1'b1;
        wait_clk(SETTLE);
        check_all("R2");

        // R3: long hold gives one step only
        gpi_n[3] = 1'b0;
        wait_clk(200);
        model(3);
        check_all("R3");
        gpi_n[3] = 1'b1;
        wait_clk(SETTLE);
        check_all("R3");

        // R5 volume sweeps up past the ceiling, then down past the floor
        for (int k = 0; k < 60; k++) press(5, "R5");
        for (int k = 0; k < 92; k++) press(4, "R5");
        chk(int'(mute), 1, "R5", "floor mute");
        // R6 unmute without level change
        press(5, "R6");
        chk(int'(vol_db), VMIN, "R6", "vol after unmute");

        // R4 tone sweeps
        for (int k = 0; k < 18; k++) press(3, "R4");
        for (int k = 0; k < 34; k++) press(2, "R4");
        for (int k = 0; k < 18; k++) press(1, "R4");
        for (int k = 0; k < 34; k++) press(0, "R4");

        // R10 premature chord; R7 suppression of second partner
        gpi_n[1] = 1'b0;
        wait_clk(SETTLE);
        model(1);
        gpi_n[5] = 1'b0;
        wait_clk(HOLD_CLKS - 100);
        check_all("R10");
        gpi_n = '1;
        wait_clk(SETTLE);
        check_all("R10");

        // R7 full chord
        gpi_n[1] = 1'b0;
        wait_clk(SETTLE);
        model(1);
        gpi_n[5] = 1'b0;
        wait_clk(HOLD_CLKS + 100);
        e_bank = 1;
        check_all("R7");
        // R9 no second switch while still holding
        gpi_n[4] = 1'b0;
        wait_clk(SETTLE);
        model(4);
        gpi_n[0] = 1'b0;
        wait_clk(HOLD_CLKS * 2 + 100);
        check_all("R9");
        gpi_n = '1;
        wait_clk(SETTLE);

        // R8 preset bank
        press(5, "R8");
        press(5, "R8");
        for (int i = 3; i >= 0; i--) press(i, "R8");
        press(4, "R8");

        // R9 return chord
        gpi_n[4] = 1'b0;
        wait_clk(SETTLE);
        model(4);
        gpi_n[0] = 1'b0;
        wait_clk(HOLD_CLKS + 100);
        e_bank = 0;
        check_all("R9");
        gpi_n = '1;
        wait_clk(SETTLE);
        press(5, "R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule